// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a serial peripheral interface master with transmit and receive queues. Software reaches it through a 32-bit word-addressed register port. Words written to the transmit data location wait in a queue. A shift engine sends them out on the data-out line and captures a word from the data-in line at the same time. The captured word goes into a receive queue, which software reads back through the receive data location. The serial clock rate is fixed at elaboration by a divider parameter, so software cannot change it.

The control word selects the clock idle level, the sampling edge, the bit order and an internal loopback path. It also holds a transmit-hold bit. While that bit is set, the transmit queue can be filled and no bits move. Once the bit is cleared, the queue drains word after word. Slave selects are active low and come from a register. They are driven either all the time (manual mode) or only while a word is being shifted (automatic mode). Writing a fixed key to the reset location returns the whole block to its power-up state.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0 and slave select reads all ones on NUM_SS bits. Status reads 0x05. The status bits are: bit0 receive empty, bit1 receive full, bit2 transmit empty, bit3 transmit full, bit4 mode fault (always 0).
- R2: A write to offset 0x68 pushes the low DATA_W bits into the transmit queue. Transmit full (status bit3) is set once FIFO_DEPTH words are held. A write made while the queue is full is discarded.
- R3: A word starts only when control bit1 (enable) and bit2 (master) are both set and bit8 (transmit hold) is clear. While bit8 is set, queued words stay queued and the serial clock does not move.
- R4: With enable clear, the serial clock stays at the control bit3 (clock idle level) value and no word is shifted.
- R5: Control bit4 selects the sampling edge: 0 samples on the leading edge, 1 samples on the trailing edge. Data out changes on the other edge. The serial clock idles at the control bit3 level.
- R6: Control bit9 set sends and assembles words least-significant bit first; clear means most-significant bit first.
- R7: Control bit0 set makes the receive side capture the block's own data-out bits and ignore the data-in pin.
- R8: Each finished word pushes exactly one word into the receive queue, read by popping offset 0x6C. If the queue is full, the word is dropped and `rx_overrun_o` pulses for one cycle.
- R9: Writing control bit5 or bit6 as 1 empties the transmit or the receive queue respectively. Both bits read back as 0.
- R10: `ss_n_o` follows the slave-select register at offset 0x70 (0 selects) while control bit7 is set. With bit7 clear it shows the register only while a word is shifting, and all ones otherwise.
- R11: Writing 0x0A to offset 0x40 restores the R1 state and empties both queues. Any other value written there has no effect.
- R12: Within a word, consecutive serial clock edges are exactly CLK_DIV system clock cycles apart, and a word makes 2*DATA_W edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at 0x6C) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NUM_SS | Active-low slave selects |
| rx_overrun_o | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The hardest state to reach from the ports is a finished word arriving while the receive queue is already full. To get there, the bench enables loopback and holds transmission with the transmit-hold bit. It then fills the transmit queue until the full flag appears, which also measures the depth. Next it releases the hold, lets the drained words fill the receive queue, and pushes one more word. All eight combinations of clock idle level, sampling edge and bit order are swept against a bench-side slave. That slave computes its own words and records the data-out line on each sampling edge.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
   localparam logic [6:0] OFS_RESET = 7'h40;
   localparam logic [6:0] OFS_CTRL  = 7'h60;
   localparam logic [6:0] OFS_STAT  = 7'h64;
   localparam logic [6:0] OFS_TXD   = 7'h68;
   localparam logic [6:0] OFS_RXD   = 7'h6C;
   localparam logic [6:0] OFS_SEL   = 7'h70;
   localparam logic [31:0] RESET_KEY = 32'h0000_000A;
   localparam int CTRL_W = 10;

   // packed from bit9 down to bit0; positions are decoded by software
   typedef struct packed {
      logic lsb_first;
      logic tx_hold;
      logic manual_sel;
      logic rx_flush;
      logic tx_flush;
      logic cpha;
      logic cpol;
      logic master;
      logic enable;
      logic loopback;
   } ctrl_t;
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sfm_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign rdata   = mem[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   // R2: a push into a full queue leaves its occupancy unchanged
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
      (full && push && !pop && !clr) |=> (full && $stable(count)));

   // R8: popping an empty queue keeps it empty
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
      (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/sfm_engine.sv
module sfm_engine #(
   parameter int W       = 8,
   parameter int CLK_DIV = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en_i,
   input  logic         cpol_i,
   input  logic         cpha_i,
   input  logic         lsb_i,
   input  logic         loop_i,
   input  logic         start_i,
   input  logic [W-1:0] tx_word_i,
   input  logic         miso_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] rx_word_o,
   output logic         sck_o,
   output logic         mosi_o
);
   localparam int IW    = $clog2(W);
   localparam int EW    = $clog2(2 * W);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   if (W < 2) begin : g_bad_width
      $error("sfm_engine: W must be at least 2");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("sfm_engine: CLK_DIV must be at least 1");
   end

   logic             busy, lvl, mosi_q, done_q;
   logic [DIV_W-1:0] div_cnt;
   logic [EW-1:0]    edge_cnt;
   logic [W-1:0]     tx_q, rx_q;
   logic             tick, leading, sample_edge, last_edge, rx_bit;
   logic [IW-1:0]    bidx;

   function automatic logic [IW-1:0] pos(input logic [IW-1:0] i, input logic lsb);
      return lsb ? i : IW'(W - 1) - i;
   endfunction

   always_comb begin
      tick        = (div_cnt == DIV_W'(CLK_DIV - 1));
      leading     = ~edge_cnt[0];
      sample_edge = leading ^ cpha_i;
      last_edge   = (edge_cnt == EW'(2 * W - 1));
      bidx        = IW'(edge_cnt >> 1);
      rx_bit      = loop_i ? mosi_q : miso_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy     <= 1'b0;
         lvl      <= 1'b0;
         mosi_q   <= 1'b0;
         done_q   <= 1'b0;
         div_cnt  <= '0;
         edge_cnt <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!en_i) begin
            busy <= 1'b0;
            lvl  <= 1'b0;
         end else if (!busy) begin
            if (start_i) begin
               busy     <= 1'b1;
               lvl      <= 1'b0;
               div_cnt  <= '0;
               edge_cnt <= '0;
               tx_q     <= tx_word_i;
               rx_q     <= '0;
               if (!cpha_i) mosi_q <= tx_word_i[pos('0, lsb_i)];
            end
         end else if (tick) begin
            div_cnt  <= '0;
            lvl      <= ~lvl;
            edge_cnt <= edge_cnt + 1'b1;
            if (sample_edge) begin
               rx_q[pos(bidx, lsb_i)] <= rx_bit;
            end else if (cpha_i) begin
               mosi_q <= tx_q[pos(bidx, lsb_i)];
            end else if (!last_edge) begin
               mosi_q <= tx_q[pos(bidx + 1'b1, lsb_i)];
            end
            if (last_edge) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end

   assign busy_o    = busy;
   assign done_o    = done_q;
   assign rx_word_o = rx_q;
   assign sck_o     = cpol_i ^ lvl;
   assign mosi_o    = mosi_q;

   // R4: an idle engine holds the clock at the idle level
   a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (sck_o == cpol_i));

   // R12: the clock only toggles after a full divider count
   a_r12_edge_pace: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && (lvl != $past(lvl))) |-> ($past(div_cnt) == DIV_W'(CLK_DIV - 1)));

   // R8: completion is a single-cycle event
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import sfm_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 4,
   parameter int NUM_SS     = 4,
   parameter int CLK_DIV    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [6:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic [NUM_SS-1:0] ss_n_o,
   output logic              rx_overrun_o
);
   if (NUM_SS < 1 || NUM_SS > 32) begin : g_bad_ss
      $error("spi_fifo_master: NUM_SS must be 1..32");
   end
   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_w
      $error("spi_fifo_master: DATA_W must be 2..32");
   end

   ctrl_t             ctrl_q, ctrl_wr;
   logic [NUM_SS-1:0] sel_q;
   logic              key_hit, core_rst, ctrl_wr_en;
   logic              tx_push, tx_flush, rx_pop, rx_flush;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [DATA_W-1:0] tx_head, rx_head, rx_word;
   logic              busy, done, start;

   assign key_hit    = bus_wr && (bus_addr == OFS_RESET) && (bus_wdata == RESET_KEY);
   assign core_rst   = rst || key_hit;
   assign ctrl_wr_en = bus_wr && (bus_addr == OFS_CTRL);
   assign tx_push    = bus_wr && (bus_addr == OFS_TXD);
   assign rx_pop     = bus_rd && (bus_addr == OFS_RXD);
   assign tx_flush   = ctrl_wr_en && bus_wdata[5];
   assign rx_flush   = ctrl_wr_en && bus_wdata[6];

   always_comb begin
      ctrl_wr          = ctrl_t'(bus_wdata[CTRL_W-1:0]);
      ctrl_wr.tx_flush = 1'b0;
      ctrl_wr.rx_flush = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (core_rst) begin
         ctrl_q <= '0;
         sel_q  <= '1;
      end else begin
         if (ctrl_wr_en) ctrl_q <= ctrl_wr;
         if (bus_wr && (bus_addr == OFS_SEL)) sel_q <= bus_wdata[NUM_SS-1:0];
      end
   end

   assign start = ctrl_q.enable && ctrl_q.master && !ctrl_q.tx_hold && !tx_empty && !busy;

   sfm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
      .clk(clk), .rst(core_rst), .clr(tx_flush),
      .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]),
      .pop(start), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
   );

   sfm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
      .clk(clk), .rst(core_rst), .clr(rx_flush),
      .push(done), .wdata(rx_word),
      .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
   );

   sfm_engine #(.W(DATA_W), .CLK_DIV(CLK_DIV)) engine_i (
      .clk(clk), .rst(core_rst),
      .en_i(ctrl_q.enable), .cpol_i(ctrl_q.cpol), .cpha_i(ctrl_q.cpha),
      .lsb_i(ctrl_q.lsb_first), .loop_i(ctrl_q.loopback),
      .start_i(start), .tx_word_i(tx_head), .miso_i(miso_i),
      .busy_o(busy), .done_o(done), .rx_word_o(rx_word),
      .sck_o(sck_o), .mosi_o(mosi_o)
   );

   assign rx_overrun_o = done && rx_full;
   assign ss_n_o       = (ctrl_q.manual_sel || busy) ? sel_q : '1;

   always_comb begin
      unique case (bus_addr)
         OFS_CTRL: bus_rdata = {{(32 - CTRL_W){1'b0}}, ctrl_q};
         OFS_STAT: bus_rdata = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
         OFS_RXD:  bus_rdata = 32'(rx_head);
         OFS_SEL:  bus_rdata = 32'(sel_q);
         default:  bus_rdata = '0;
      endcase
   end

   // R3: with the hold bit set the engine does not leave idle
   a_r3_hold_blocks: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q.tx_hold && !busy) |=> !busy);

   // R9: a transmit flush empties the queue on the next cycle
   a_r9_tx_flush: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr_en && bus_wdata[5]) |=> tx_empty);

   // R11: the key write restores the default register state
   a_r11_key_reset: assert property (@(posedge clk) disable iff (rst)
      key_hit |=> (ctrl_q == '0 && sel_q == '1 && tx_empty && rx_empty && !busy));
endmodule

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
   localparam int W     = 8;
   localparam int DEPTH = 4;
   localparam int NSS   = 4;
   localparam int DIV   = 3;
   localparam int WORD_CYC = 2 * W * DIV + 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [6:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic sck, mosi, miso, ovr;
   logic [NSS-1:0] ss_n;

   int compared = 0, mismatched = 0;

   // bench-side slave / monitor state
   logic   mon_clr = 1'b0;
   logic   tb_cpol = 1'b0, tb_cpha = 1'b0, tb_lsb = 1'b0;
   logic   force_en = 1'b0, force_val = 1'b0;
   int     salt = 0;
   int     sidx, edge_n, gap, bad_gap, ovr_cnt;
   logic   prev_sck;
   logic [W-1:0] mon_word [16];
   logic   slave_bit;

   always #5 clk = ~clk;

   spi_fifo_master #(.DATA_W(W), .FIFO_DEPTH(DEPTH), .NUM_SS(NSS), .CLK_DIV(DIV)) dut_i (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck), .mosi_o(mosi),
      .miso_i(miso), .ss_n_o(ss_n), .rx_overrun_o(ovr)
   );

   function automatic logic [W-1:0] slv(input int k, input int s);
      return W'(k * 91 + 60 + s * 13);
   endfunction
   function automatic logic [W-1:0] txw(input int k, input int s);
      return W'(k * 41 + 165 + s * 7) ^ W'(8'h5A);
   endfunction

   always_comb begin
      automatic logic [W-1:0] sw = slv(sidx / W, salt);
      automatic int b = sidx % W;
      slave_bit = tb_lsb ? sw[b] : sw[W-1-b];
   end
   assign miso = force_en ? force_val : slave_bit;

   always @(negedge clk) begin
      if (mon_clr) begin
         sidx = 0; edge_n = 0; gap = 0; bad_gap = 0; ovr_cnt = 0;
         prev_sck = sck;
         for (int k = 0; k < 16; k++) mon_word[k] = '0;
      end else begin
         gap++;
         if (sck !== prev_sck) begin
            if (edge_n >= 1 && edge_n < 2 * W && gap != DIV) bad_gap++;
            edge_n++;
            gap = 0;
            if (sck == (tb_cpol ^ ~tb_cpha)) begin
               if (sidx / W < 16) begin
                  if (tb_lsb) mon_word[sidx / W][sidx % W] = mosi;
                  else        mon_word[sidx / W][W - 1 - sidx % W] = mosi;
               end
               sidx++;
            end
         end
         prev_sck = sck;
         if (ovr) ovr_cnt++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic mclr();
      @(posedge clk); mon_clr = 1'b1;
      @(posedge clk); mon_clr = 1'b0;
   endtask

   task automatic setmode(input logic pol, input logic pha, input logic lsb, input int s);
      @(posedge clk);
      tb_cpol = pol; tb_cpha = pha; tb_lsb = lsb; salt = s;
   endtask

   initial begin
      #(200000 * 10);
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (4) @(posedge clk);
      rst = 1'b0;
      mclr();

      // R1 reset state
      rd(7'h64, d); chk("R1 status", d, 32'h05);
      rd(7'h60, d); chk("R1 ctrl", d, 32'h0);
      rd(7'h70, d); chk("R1 select reg", d, 32'hF);
      chk("R1 ss_n", 32'(ss_n), 32'hF);
      chk("R1 sck", 32'(sck), 32'h0);

      // R5 R6 R12 sweep over clock mode and bit order
      for (int cfg = 0; cfg < 8; cfg++) begin
         logic pha, pol, lsb;
         pha = cfg[0]; pol = cfg[1]; lsb = cfg[2];
         wr(7'h40, 32'h0A);
         setmode(pol, pha, lsb, cfg);
         force_en = 1'b0;
         wr(7'h70, 32'hE);
         wr(7'h60, 32'h186 | (32'(pol) << 3) | (32'(pha) << 4) | (32'(lsb) << 9));
         wr(7'h68, 32'(txw(0, cfg)));
         wr(7'h68, 32'(txw(1, cfg)));
         mclr();
         wr(7'h60, 32'h086 | (32'(pol) << 3) | (32'(pha) << 4) | (32'(lsb) << 9));
         waitc(2 * WORD_CYC + 20);
         for (int k = 0; k < 2; k++) begin
            rd(7'h6C, d);
            chk($sformatf("R5 R6 rx word %0d cfg %0d", k, cfg), d, 32'(slv(k, cfg)));
            chk($sformatf("R5 R6 mosi word %0d cfg %0d", k, cfg), 32'(mon_word[k]), 32'(txw(k, cfg)));
         end
         chk($sformatf("R12 edge spacing cfg %0d", cfg), 32'(bad_gap), 32'h0);
         chk($sformatf("R12 edge count cfg %0d", cfg), 32'(edge_n), 32'(4 * W));
         chk($sformatf("R5 idle level cfg %0d", cfg), 32'(sck), 32'(pol));
      end

      // R4 enable clear: clock at idle level, nothing moves
      wr(7'h40, 32'h0A);
      setmode(1'b1, 1'b0, 1'b0, 20);
      wr(7'h60, 32'h00C);
      wr(7'h68, 32'h33);
      mclr();
      waitc(150);
      chk("R4 sck idle", 32'(sck), 32'h1);
      chk("R4 no edges", 32'(edge_n), 32'h0);
      rd(7'h64, d); chk("R4 status", d, 32'h01);

      // R3 transmit hold
      wr(7'h40, 32'h0A);
      setmode(1'b0, 1'b0, 1'b0, 21);
      wr(7'h60, 32'h106);
      wr(7'h68, 32'(txw(0, 21)));
      mclr();
      waitc(150);
      chk("R3 no edges under hold", 32'(edge_n), 32'h0);
      rd(7'h64, d); chk("R3 status under hold", d, 32'h01);
      wr(7'h60, 32'h006);
      waitc(WORD_CYC + 10);
      rd(7'h64, d); chk("R3 released status", d, 32'h04);

      // R9 flushes
      wr(7'h60, 32'h046);
      rd(7'h64, d); chk("R9 rx flush", d, 32'h05);
      wr(7'h60, 32'h106);
      wr(7'h68, 32'h11);
      wr(7'h68, 32'h22);
      rd(7'h64, d); chk("R9 tx loaded", d, 32'h01);
      wr(7'h60, 32'h126);
      rd(7'h64, d); chk("R9 tx flush", d, 32'h05);
      rd(7'h60, d); chk("R9 flush bits read 0", d, 32'h106);

      // R2 depth discovery, R7 loopback, R8 overrun
      wr(7'h40, 32'h0A);
      setmode(1'b0, 1'b0, 1'b0, 30);
      force_en = 1'b1; force_val = 1'b1;
      wr(7'h60, 32'h107);
      n = 0;
      do begin
         wr(7'h68, 32'(txw(n, 30)));
         n++;
         rd(7'h64, d);
      end while (!d[3] && n < 10);
      chk("R2 depth at full", 32'(n), 32'(DEPTH));
      wr(7'h68, 32'hEE);
      mclr();
      wr(7'h60, 32'h007);
      waitc(DEPTH * WORD_CYC + 20);
      rd(7'h64, d); chk("R8 rx full status", d, 32'h06);
      wr(7'h68, 32'(txw(5, 30)));
      waitc(WORD_CYC + 10);
      chk("R8 overrun pulses", 32'(ovr_cnt), 32'h1);
      for (int k = 0; k < DEPTH; k++) begin
         rd(7'h6C, d);
         chk($sformatf("R7 R2 loopback word %0d", k), d, 32'(txw(k, 30)));
      end
      rd(7'h64, d); chk("R8 drained", d, 32'h05);
      force_en = 1'b0;

      // R10 slave select modes
      wr(7'h40, 32'h0A);
      setmode(1'b0, 1'b0, 1'b0, 40);
      wr(7'h70, 32'hB);
      wr(7'h60, 32'h080);
      chk("R10 manual", 32'(ss_n), 32'hB);
      wr(7'h60, 32'h006);
      chk("R10 auto idle", 32'(ss_n), 32'hF);
      wr(7'h68, 32'h5C);
      waitc(6);
      chk("R10 auto active", 32'(ss_n), 32'hB);
      waitc(WORD_CYC + 10);
      chk("R10 auto after", 32'(ss_n), 32'hF);

      // R11 key reset
      wr(7'h60, 32'h30E);
      wr(7'h40, 32'h05);
      rd(7'h60, d); chk("R11 wrong key ignored", d, 32'h30E);
      wr(7'h40, 32'h0A);
      rd(7'h60, d); chk("R11 ctrl", d, 32'h0);
      rd(7'h70, d); chk("R11 select", d, 32'hF);
      rd(7'h64, d); chk("R11 status", d, 32'h05);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule